// File: doc/BRIEF.md
# Level-Mirrored Interrupt Aggregator

This block gathers up to eight level-sensitive request lines coming from on-chip sub-functions (line 0 storage controller, line 1 card interface, line 2 USB host, line 3 serial port, line 4 display, lines 5 to 7 unused) and merges them into a single request toward the host processor. Each line's level is copied into a bit of a status register. The status register is gated bit by bit with an enable (mask) register, and the single output is raised whenever any enabled status bit is set.

Software reaches both registers over a plain byte-wide register bus. The bus has a write strobe, an address and write data. Read data is combinational and follows the address. Software may overwrite the status register. A written bit keeps its value until the line it belongs to changes level, and from that point the bit again follows the line. No stream data passes through the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

Top module: `irqagg_top`

## Requirements
- R1: After reset the status register and the mask register both read 0x00, and `irq_o` is low.
- R2: When a source line goes from low to high, its status bit (bit i for line i) reads 1 starting with the first clock edge after the change.
- R3: When a source line goes from high to low, its status bit reads 0 starting with the first clock edge after the change.
- R4: `irq_o` is high exactly when the bitwise AND of status and mask is nonzero. It follows any status or mask update with no extra cycle, and it stays low while the mask is 0x00.
- R5: A bus write to the status address (default 0x20) replaces every status bit with the written data bit at that clock edge. A written bit then holds while its line stays at a constant level.
- R6: When a line changes level in the same cycle as a status write, that bit takes the line's new level. The other bits take the written value.
- R7: A bus write to the mask address (default 0x21) loads the mask at that clock edge. Reading that address returns the mask.
- R8: A read from any address other than the status and mask addresses returns 0x00. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl_i | input | NLINES (8) | Level of each sub-function request line |
| bus_wr_i | input | 1 | Register write strobe, one byte per cycle |
| bus_addr_i | input | ADDR_W (8) | Register address for read and write |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational from address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each status bit holds a copy of the last line level seen together with the bit value. A stale copy shows up as a status bit that fails to follow a line one edge after the line changes. A wrong priority between a line change and a software write shows up at the single bus read that follows the collision cycle. Mask or gating faults reach `irq_o` in the same cycle the register changes. Every bus read in the bench therefore also compares `irq_o`, and any wrong state becomes visible at most one clock after the stimulus that exposes it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DATA_W = 8;
  localparam int MAX_LINES = 8;
  localparam logic [7:0] STAT_ADDR_DEF = 8'h20;
  localparam logic [7:0] MASK_ADDR_DEF = 8'h21;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqagg_line.sv
module irqagg_line (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic sw_we_i,
  input  logic sw_bit_i,
  output logic stat_o
);
  logic seen_q;
  logic stat_q;
  logic moved;

  assign moved = lvl_i ^ seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      seen_q <= lvl_i;
      if (moved)        stat_q <= lvl_i;
      else if (sw_we_i) stat_q <= sw_bit_i;
    end
  end

  assign stat_o = stat_q;

  // R2 / R3: a level change is mirrored one edge later
  a_r2_mirror_level: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i != seen_q) |=> (stat_q == $past(lvl_i)));
  // R5: with a quiet line and no write, the bit holds
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_i == seen_q) && !sw_we_i) |=> $stable(stat_q));
  // R6: a line change beats a software write in the same cycle
  a_r6_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_i != seen_q) && sw_we_i && (sw_bit_i != lvl_i)) |=> (stat_q == $past(lvl_i)));
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NLINES = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_ADDR_DEF),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_ADDR_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NLINES-1:0] stat_i,
  output logic              stat_we_o,
  output logic [NLINES-1:0] stat_wdata_o,
  output logic [NLINES-1:0] mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e           sel;
  logic [NLINES-1:0]  mask_q;

  always_comb begin
    if (addr_i == STAT_ADDR)      sel = SEL_STAT;
    else if (addr_i == MASK_ADDR) sel = SEL_MASK;
    else                          sel = SEL_NONE;
  end

  assign stat_we_o    = wr_i && (sel == SEL_STAT);
  assign stat_wdata_o = wdata_i[NLINES-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                           mask_q <= '0;
    else if (wr_i && (sel == SEL_MASK))   mask_q <= wdata_i[NLINES-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = DATA_W'(stat_i);
      SEL_MASK: rdata_o = DATA_W'(mask_q);
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;

  // R7: a mask write lands on the next edge
  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (addr_i == MASK_ADDR)) |=> (mask_q == $past(wdata_i[NLINES-1:0])));
  // R8: writes elsewhere leave the mask alone
  a_r8_unmapped_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (addr_i != MASK_ADDR)) |=> $stable(mask_q));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NLINES = MAX_LINES,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_ADDR_DEF),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_ADDR_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] src_lvl_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);
  logic              stat_we;
  logic [NLINES-1:0] stat_wdata;
  logic [NLINES-1:0] stat;
  logic [NLINES-1:0] mask;

  irqagg_regs #(
    .ADDR_W(ADDR_W), .NLINES(NLINES),
    .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .stat_i(stat), .stat_we_o(stat_we), .stat_wdata_o(stat_wdata),
    .mask_o(mask), .rdata_o(bus_rdata_o)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    irqagg_line u_line (
      .clk(clk), .rst_n(rst_n),
      .lvl_i(src_lvl_i[i]),
      .sw_we_i(stat_we),
      .sw_bit_i(stat_wdata[i]),
      .stat_o(stat[i])
    );
  end

  assign irq_o = |(stat & mask);

  // R4: no request while everything is masked
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);
  // R4: a request always has a status bit behind it
  a_r4_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat != '0));
  // R1: the cycle after reset release, nothing is pending
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (mask == '0) && (stat == '0));
endmodule

// File: tb/irqagg_top_bench.sv
module irqagg_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic       chk_req = 1'b0;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_MASK = 8'h21;

  typedef struct {
    logic [7:0] data;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  irqagg_top u_irqagg_top (
    .clk(clk), .rst_n(rst_n), .src_lvl_i(src),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic cycle();
    @(posedge clk); #2;
    wr = 1'b0;
    chk_req = 1'b0;
  endtask

  task automatic set_src(input logic [7:0] v);
    cycle();
    src = v;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    cycle();
    wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic expect_read(input logic [7:0] a, input logic [7:0] d,
                             input logic i, input string tag);
    exp_t e;
    cycle();
    addr = a;
    e.data = d; e.irq = i; e.tag = tag;
    sb.push_back(e);
    chk_req = 1'b1;
  endtask

  always @(negedge clk) begin
    if (chk_req) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: rdata=%02h irq=%0b", rdata, irq);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.data || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                   e.tag, rdata, irq, e.data, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1
    expect_read(A_STAT, 8'h00, 1'b0, "R1 status after reset");
    expect_read(A_MASK, 8'h00, 1'b0, "R1 mask after reset");

    // R2: lines 0 and 2 rise, mask still closed (R4)
    set_src(8'h05);
    expect_read(A_STAT, 8'h05, 1'b0, "R2 rise mirrored, R4 masked off");

    // R7 and R4: open line 2
    bus_write(A_MASK, 8'h04);
    expect_read(A_MASK, 8'h04, 1'b1, "R7 mask readback, R4 request");

    // R3: line 2 falls
    set_src(8'h01);
    expect_read(A_STAT, 8'h01, 1'b0, "R3 fall mirrored, R4 drops");

    // R5: overwrite status, lines quiet
    bus_write(A_STAT, 8'hF0);
    expect_read(A_STAT, 8'hF0, 1'b0, "R5 status overwrite");
    bus_write(A_MASK, 8'h10);
    expect_read(A_STAT, 8'hF0, 1'b1, "R4 written bit drives request");
    cycle(); cycle(); cycle();
    expect_read(A_STAT, 8'hF0, 1'b1, "R5 written value holds");

    // R5: only the changed line re-mirrors
    set_src(8'h03);
    expect_read(A_STAT, 8'hF2, 1'b1, "R5 changed line re-mirrors");

    // R6: line 0 falls during a status write
    cycle();
    src = 8'h02;
    wr = 1'b1; addr = A_STAT; wdata = 8'h81;
    expect_read(A_STAT, 8'h80, 1'b0, "R6 change beats write");

    // R8: unmapped write and read
    bus_write(8'h22, 8'hFF);
    expect_read(A_MASK, 8'h10, 1'b0, "R8 mask untouched");
    expect_read(A_STAT, 8'h80, 1'b0, "R8 status untouched");
    expect_read(8'h22, 8'h00, 1'b0, "R8 unmapped read zero");

    // R4: mask and status edits reflect immediately
    bus_write(A_MASK, 8'h80);
    expect_read(A_MASK, 8'h80, 1'b1, "R4 mask opens line 7");
    bus_write(A_STAT, 8'h00);
    expect_read(A_STAT, 8'h00, 1'b0, "R4 status cleared drops request");

    // R2: line 7 rises while enabled
    set_src(8'h82);
    expect_read(A_STAT, 8'h80, 1'b1, "R2 line 7 rise requests");

    // R3: line 7 falls
    set_src(8'h02);
    expect_read(A_STAT, 8'h00, 1'b0, "R3 line 7 fall clears");

    cycle();
    cycle();
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover %0d items, expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule